// File: doc/BRIEF.md
# Rank Interleave Decoder

This block takes an address that is already local to one memory channel and works out which DIMM and which rank hold it. It also computes the address inside that rank. Software first loads two kinds of configuration word through a simple write port:

- **Range words.** Each one carries a valid flag, an upper limit and an interleave way count.
- **Interleave words.** There is one for each way of each range. Each carries an offset and a channel-rank number.

A closed-page input selects which address bit the rank interleave starts at.

A lookup is offered on a valid/ready input. The block compares the address against the ranges in index order and takes the first valid range that covers it. It then removes the rank interleave from the address. The remainder of that division picks the interleave word, which provides an offset to subtract and the channel rank. One cycle after acceptance the result appears on a valid/ready output. If no range covers the address, the result carries an error flag instead.

Top module: `rank_ilv_decoder`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high and every configuration word reads as zero (all ranges invalid).
- R2: The limit of range word k is `{word[11:1], 29 ones}`. Range k matches when `word[31]` is set and `low_k <= addr <= limit_k`. The lower bound `low_0` is zero. Each later `low_k` equals `limit_(k-1)` itself, whether or not range k-1 is valid.
- R3: When several valid ranges cover the address, the range with the lowest index is used.
- R4: The interleave shift `s` is 6 while `close_page` is high and 13 while it is low.
- R5: The way count is `W = 1 << word[29:28]`. The pre-offset rank address is `((addr >> s) / W) << s`, OR-ed with `addr[s-1:0]`.
- R6: The way index is `((addr >> s) mod W)` reduced to its low two bits. The interleave word used is the one at (way index, matched range).
- R7: `out_rank_addr` is the pre-offset rank address minus `(ilv[15:2] << 26)`, modulo 2^ADDR_W. `out_chan_rank` is `ilv[19:16]`.
- R8: `out_dimm` is the channel rank divided by 4. `out_rank` is the channel rank mod 4.
- R9: When no valid range covers the address, the result has `out_err` high and `out_dimm`, `out_rank`, `out_chan_rank` and `out_rank_addr` all zero.
- R10: The result appears on the cycle after the input handshake. While `out_valid` is high and `out_ready` is low, the result is held and `in_ready` stays low.
- R11: A write with `cfg_sel` = 0 stores `cfg_wdata` into range word `cfg_idx[1:0]`. A write with `cfg_sel` = 1 stores it into the interleave word with way `cfg_idx[3:2]` and range `cfg_idx[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects range words, 1 selects interleave words |
| cfg_idx | input | 4 | Word index: way in [3:2], range in [1:0] |
| cfg_wdata | input | 32 | Configuration write data |
| close_page | input | 1 | Closed-page mode; selects the interleave shift |
| in_valid | input | 1 | Lookup request valid |
| in_ready | output | 1 | Lookup request accepted |
| in_addr | input | ADDR_W | Channel-local address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed |
| out_err | output | 1 | No range covered the address |
| out_dimm | output | 2 | DIMM index |
| out_rank | output | 2 | Rank within the DIMM |
| out_chan_rank | output | 4 | Channel rank number |
| out_rank_addr | output | ADDR_W | Address inside the rank |

## Verification
The properties assume that the consumer obeys the output handshake: a result leaves only through a cycle with `out_ready` high. They also assume that `in_valid` is sampled only while `in_ready` is high. The stimulus drives a single request at a time. It rewrites configuration only while no result is pending, and it keeps `close_page` steady between the input handshake and the check of the result. Expected values come from a separate arithmetic model of the range, division and offset rules, and from results worked out by hand.

// File: rtl/rank_ilv_decoder.sv
module rank_ilv_decoder #(
  parameter int ADDR_W  = 40,
  parameter int NRANGE  = 4,
  parameter int NWAY    = 4,
  parameter int LIM_LSB = 29,
  parameter int OFF_LSB = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [3:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              close_page,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_err,
  output logic [1:0]        out_dimm,
  output logic [1:0]        out_rank,
  output logic [3:0]        out_chan_rank,
  output logic [ADDR_W-1:0] out_rank_addr
);
  localparam int EW    = $clog2(NRANGE);
  localparam int WW    = $clog2(NWAY);
  localparam int LIM_W = 11 + LIM_LSB;

  logic [31:0] rng_q [NRANGE];
  logic [31:0] ilv_q [NWAY][NRANGE];

  function automatic logic [ADDR_W-1:0] lim_of(input logic [31:0] w);
    logic [ADDR_W-1:0] r;
    r = '0;
    r[LIM_W-1:0] = {w[11:1], {LIM_LSB{1'b1}}};
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NRANGE; e++) begin
        rng_q[e] <= '0;
        for (int w = 0; w < NWAY; w++) ilv_q[w][e] <= '0;
      end
    end else if (cfg_we) begin
      if (!cfg_sel) rng_q[cfg_idx[EW-1:0]] <= cfg_wdata;
      else          ilv_q[cfg_idx[2+WW-1:2]][cfg_idx[EW-1:0]] <= cfg_wdata;
    end
  end

  logic          hit;
  logic [EW-1:0] hit_idx;
  logic [ADDR_W-1:0] lo_b, lim_b;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    lo_b = '0;
    lim_b = '0;
    for (int i = 0; i < NRANGE; i++) begin
      lim_b = lim_of(rng_q[i]);
      if (!hit && rng_q[i][31] && lo_b <= in_addr && in_addr <= lim_b) begin
        hit = 1'b1;
        hit_idx = i[EW-1:0];
      end
      lo_b = lim_b;
    end
  end

  logic [31:0]       sel_rng, sel_ilv;
  logic [1:0]        wl;
  logic [3:0]        sh;
  logic [ADDR_W-1:0] hi, low_mask, pre_addr, offset;
  logic [WW-1:0]     way;
  logic [WW-1:0]     way_mask;

  assign sel_rng  = rng_q[hit_idx];
  assign wl       = sel_rng[29:28];
  assign sh       = close_page ? 4'd6 : 4'd13;
  assign hi       = in_addr >> sh;
  assign low_mask = (ADDR_W'(1) << sh) - ADDR_W'(1);
  assign pre_addr = ((hi >> wl) << sh) | (in_addr & low_mask);
  assign way_mask = (wl == 2'd0) ? '0 : (wl == 2'd1) ? WW'(1) : '1;
  assign way      = hi[WW-1:0] & way_mask;
  assign sel_ilv  = ilv_q[way][hit_idx];
  assign offset   = ADDR_W'({sel_ilv[15:2], {OFF_LSB{1'b0}}});

  logic unused_bits;
  assign unused_bits = ^{sel_rng[30], sel_rng[27:12], sel_rng[0], sel_ilv[31:20], sel_ilv[1:0]};

  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_err       <= 1'b0;
      out_dimm      <= '0;
      out_rank      <= '0;
      out_chan_rank <= '0;
      out_rank_addr <= '0;
    end else if (accept) begin
      out_valid     <= 1'b1;
      out_err       <= !hit;
      out_chan_rank <= hit ? sel_ilv[19:16] : 4'd0;
      out_dimm      <= hit ? sel_ilv[19:18] : 2'd0;
      out_rank      <= hit ? sel_ilv[17:16] : 2'd0;
      out_rank_addr <= hit ? pre_addr - offset : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

module rank_ilv_decoder_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_err,
  input logic [3:0]        out_chan_rank,
  input logic [ADDR_W-1:0] out_rank_addr
);
  // R10
  accept_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rank_addr) && $stable(out_chan_rank) && $stable(out_err));
  // R10
  result_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));
  // R9
  err_payload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_chan_rank == 4'd0 && out_rank_addr == '0);
  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind rank_ilv_decoder rank_ilv_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err),
  .out_chan_rank(out_chan_rank), .out_rank_addr(out_rank_addr));

// File: tb/rank_ilv_decoder_test.sv
module rank_ilv_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [3:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic close_page = 0, in_valid = 0, out_ready = 1;
  logic [AW-1:0] in_addr = '0;
  logic in_ready, out_valid, out_err;
  logic [1:0] out_dimm, out_rank;
  logic [3:0] out_chan_rank;
  logic [AW-1:0] out_rank_addr;

  int checks = 0, fails = 0;
  logic [31:0] rng_m [4];
  logic [31:0] ilv_m [4][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_ilv_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .close_page(close_page), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err),
    .out_dimm(out_dimm), .out_rank(out_rank), .out_chan_rank(out_chan_rank),
    .out_rank_addr(out_rank_addr));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    if (!sel) rng_m[idx[1:0]] = d; else ilv_m[idx[3:2]][idx[1:0]] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [31:0] rword(input logic v, input int wl, input int lf);
    return (32'(v) << 31) | (32'(wl) << 28) | (32'(lf) << 1);
  endfunction

  function automatic void model(input logic [AW-1:0] a, input logic cp, output logic e,
                                output logic [3:0] cr, output logic [AW-1:0] ra);
    logic [63:0] lo, lim, q, ways, base;
    int hit, sh, w;
    hit = -1; lo = 0;
    for (int i = 0; i < 4; i++) begin
      lim = (64'(rng_m[i][11:1]) << 29) | 64'h1FFF_FFFF;
      if (hit < 0 && rng_m[i][31] && lo <= 64'(a) && 64'(a) <= lim) hit = i;
      lo = lim;
    end
    e = (hit < 0); cr = 0; ra = 0;
    if (hit >= 0) begin
      sh = cp ? 6 : 13;
      ways = 64'd1 << rng_m[hit][29:28];
      q = 64'(a) >> sh;
      w = int'((q % ways) % 4);
      base = ((q / ways) << sh) | (64'(a) % (64'd1 << sh));
      ra = AW'(base - (64'(ilv_m[w][hit][15:2]) << 26));
      cr = ilv_m[w][hit][19:16];
    end
  endfunction

  task automatic issue(input logic [AW-1:0] a, input logic cp);
    @(negedge clk);
    close_page = cp; in_addr = a; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_decode(input string req, input logic [AW-1:0] a, input logic cp);
    logic e; logic [3:0] cr; logic [AW-1:0] ra;
    model(a, cp, e, cr, ra);
    issue(a, cp);
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " err"}, 64'(out_err), 64'(e));
    check({req, " chan_rank"}, 64'(out_chan_rank), 64'(cr));
    check({req, " R8 dimm"}, 64'(out_dimm), 64'(cr / 4));
    check({req, " R8 rank"}, 64'(out_rank), 64'(cr % 4));
    check({req, " rank_addr"}, 64'(out_rank_addr), 64'(ra));
  endtask

  task automatic t_hand(input string req, input logic [AW-1:0] a, input logic cp,
                        input logic [3:0] cr, input logic [AW-1:0] ra);
    issue(a, cp);
    check({req, " chan_rank"}, 64'(out_chan_rank), 64'(cr));
    check({req, " dimm"}, 64'(out_dimm), 64'(cr[3:2]));
    check({req, " rank"}, 64'(out_rank), 64'(cr[1:0]));
    check({req, " rank_addr"}, 64'(out_rank_addr), 64'(ra));
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);
    for (int i = 0; i < 4; i++) begin
      rng_m[i] = 0;
      for (int w = 0; w < 4; w++) ilv_m[w][i] = 0;
    end
    issue(40'h0000_1000, 1'b1);
    check("R1 empty config err", 64'(out_err), 64'd1);
  endtask

  task automatic t_config();
    wr(0, 4'd0, rword(1, 0, 1));
    wr(0, 4'd1, rword(1, 2, 3));
    wr(0, 4'd2, rword(0, 0, 5));
    wr(0, 4'd3, rword(1, 1, 7));
    for (int w = 0; w < 4; w++)
      for (int e = 0; e < 4; e++)
        wr(1, 4'(w * 4 + e), (32'(w * 4 + e) << 16) | (32'(e + 1) << 2));
  endtask

  task automatic t_handshake();
    @(negedge clk);
    out_ready = 0; in_addr = 40'h0012_3456; close_page = 1; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);
    check("R10 held valid", 64'(out_valid), 64'd1);
    check("R10 in_ready low", 64'(in_ready), 64'd0);
    check("R10 held addr", 64'(out_rank_addr), 64'h0012_3456 - 64'h0400_0000 & 64'hFF_FFFF_FFFF);
    out_ready = 1;
    @(negedge clk);
    check("R10 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_config();
    t_hand("R7 single way offset", 40'h1234_5678, 1'b1, 4'd0, 40'h0E34_5678);
    t_hand("R5 closed four way", 40'h4000_0100, 1'b1, 4'd1, 40'h0800_0040);
    t_hand("R4 open four way", 40'h4000_0100, 1'b0, 4'd1, 40'h0800_0100);
    t_hand("R6 way one", 40'h4000_0140, 1'b1, 4'd5, 40'h0800_0040);
    t_decode("R3 first match", 40'h3FFF_FFFF, 1'b1);
    t_decode("R4 open", 40'h5A5A_5A5A, 1'b0);
    t_decode("R4 closed", 40'h5A5A_5A5A, 1'b1);
    t_decode("R2 gap after invalid", 40'hA000_0000, 1'b1);
    t_decode("R2 inclusive lower", 40'hBFFF_FFFF, 1'b0);
    t_decode("R6 two way", 40'hC000_2040, 1'b0);
    t_decode("R9 above all", 40'h1_0000_0000, 1'b1);
    t_handshake();
    wr(1, 4'b0100, (32'd14 << 16) | (32'd3 << 2));
    t_hand("R11 ilv rewrite", 40'h1234_5678, 1'b1, 4'd0, 40'h0E34_5678);
    wr(1, 4'b0000, (32'd14 << 16) | (32'd3 << 2));
    t_hand("R11 ilv way0 range0", 40'h1234_5678, 1'b1, 4'd14, 40'h0634_5678);
    wr(0, 4'd0, rword(0, 0, 1));
    t_decode("R11 range disable", 40'h1234_5678, 1'b1);
    check("R11 range disable err", 64'(out_err), 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule